// File: doc/BRIEF.md
# Vectored Interrupt Source State Machine

This block is one interrupt source on a daisy-chained vectored interrupt system. A peripheral holds a level request. The block turns that request into a pending flag and an interrupt output for the chain. When the processor acknowledges the pending source, the block marks itself in service and withdraws its interrupt. When a return-from-interrupt is decoded, the block leaves service.

The main rule concerns requests that arrive during service. A request that is active while the source is in service is ignored. A return-from-interrupt clears only the in-service flag. The request can then raise the source again, but only on a later cycle. Because of this, a second acknowledge cannot take the service that is already running. If the request is dropped, all state clears in the next cycle, whatever else is happening.

All state is registered. Each input is sampled on the rising clock edge, and the outputs change in the cycle after that edge.

Top module: `irq_src_fsm`

## Requirements
- R1: When `req_i` is low on a clock edge, `pend_o`, `insvc_o` and `int_o` are all 0 after that edge, whatever `ack_i` and `reti_i` are.
- R2: When `req_i` is high and the source is in service, the request is ignored unless `reti_i` is also high: `insvc_o` stays 1 and `pend_o` stays 0, even if `ack_i` is high.
- R3: When `req_i` is high, the source is not in service, and no acknowledge is taken (`ack_i` low, or `pend_o` low), `pend_o` and `int_o` are 1 after the edge.
- R4: When `reti_i` is high while the source is in service, `insvc_o` clears after the edge, and `int_o` then equals `pend_o`.
- R5: An in-service source never reaches the pending state in the cycle right after service. At least one cycle with `pend_o` = 0 and `insvc_o` = 0 comes between them.
- R6: When `ack_i` is high while the source is pending and `req_i` is high, `pend_o` clears, `insvc_o` sets and `int_o` drops after the edge.
- R7: `ack_i` has no effect unless the source is pending. `reti_i` has no effect unless the source is in service.
- R8: While `rst_n` is low, `pend_o`, `insvc_o` and `int_o` are 0.
- R9: `pend_o` and `insvc_o` are never both 1, and `int_o` always equals `pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Level request from the peripheral, high = requesting |
| ack_i | input | 1 | Acknowledge cycle aimed at this source |
| reti_i | input | 1 | Decoded return-from-interrupt |
| pend_o | output | 1 | Pending flag |
| insvc_o | output | 1 | In-service flag |
| int_o | output | 1 | Interrupt output to the chain |

## Verification
The bench puts the source in each of its three states: idle, pending and in service. From each state it applies all eight combinations of request, acknowledge and return for one cycle, and compares the result with a next-state model that the bench computes itself. These combinations separate four things: a dropped request, an ignored request, a taken acknowledge, and a stray acknowledge or stray return. A directed sequence holds the request high through a return-from-interrupt to show that the source goes back to pending only after an idle cycle. A further test applies reset while the source is in service.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  // Encoding of the source state: {pending, in_service}
  typedef enum logic [1:0] {
    SRC_IDLE = 2'b00,
    SRC_SVC  = 2'b01,
    SRC_PEND = 2'b10
  } src_state_e;

  // Next-state rule for one source; a dropped request wins over everything
  function automatic src_state_e src_next(
    input src_state_e cur,
    input logic       req,
    input logic       ack,
    input logic       reti
  );
    src_state_e nxt;
    if (!req)
      nxt = SRC_IDLE;
    else if (cur == SRC_SVC)
      nxt = reti ? SRC_IDLE : SRC_SVC;   // no direct return to pending
    else if (cur == SRC_PEND && ack)
      nxt = SRC_SVC;
    else
      nxt = SRC_PEND;
    return nxt;
  endfunction

endpackage

// File: rtl/irq_src_event.sv
module irq_src_event
  import irq_src_pkg::*;
(
  input  src_state_e cur_i,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic       reti_i,
  output logic       ev_drop_o,
  output logic       ev_take_o,
  output logic       ev_leave_o,
  output logic       ev_block_o
);

  logic in_svc;
  logic pending;

  assign in_svc  = (cur_i == SRC_SVC);
  assign pending = (cur_i == SRC_PEND);

  // Named events, used by the checker and for debug visibility
  assign ev_drop_o  = !req_i;
  assign ev_take_o  = req_i && pending && ack_i;
  assign ev_leave_o = req_i && in_svc && reti_i;
  assign ev_block_o = req_i && in_svc && !reti_i;

endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       ack_i,
  input  logic       reti_i,
  output src_state_e state_o
);

  src_state_e state_q;
  src_state_e state_d;

  always_comb state_d = src_next(state_q, req_i, ack_i, reti_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SRC_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
  import irq_src_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  input  logic reti_i,
  output logic pend_o,
  output logic insvc_o,
  output logic int_o
);

  src_state_e state;
  logic       ev_drop;
  logic       ev_take;
  logic       ev_leave;
  logic       ev_block;

  irq_src_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .ack_i   (ack_i),
    .reti_i  (reti_i),
    .state_o (state)
  );

  irq_src_event u_event (
    .cur_i      (state),
    .req_i      (req_i),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .ev_drop_o  (ev_drop),
    .ev_take_o  (ev_take),
    .ev_leave_o (ev_leave),
    .ev_block_o (ev_block)
  );

  assign pend_o  = state[1];
  assign insvc_o = state[0];
  assign int_o   = state[1];   // interrupt is driven from the pending flag

endmodule

// File: rtl/irq_src_chk.sv
module irq_src_chk (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic ack_i,
  input logic reti_i,
  input logic pend_o,
  input logic insvc_o,
  input logic int_o,
  input logic ev_drop,
  input logic ev_take,
  input logic ev_leave,
  input logic ev_block
);

  assert_drop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (!pend_o && !insvc_o && !int_o));

  assert_block_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_block |=> (insvc_o && !pend_o));

  assert_raise_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !insvc_o && !(ack_i && pend_o)) |=> (pend_o && int_o));

  assert_reti_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leave |=> (!insvc_o && (int_o == pend_o)));

  assert_no_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_o |=> !pend_o);

  assert_ack_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> (insvc_o && !pend_o && !int_o));

  assert_stray_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !pend_o && !req_i) |=> (!pend_o && !insvc_o));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_o && insvc_o));

endmodule

bind irq_src_fsm irq_src_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .ack_i    (ack_i),
  .reti_i   (reti_i),
  .pend_o   (pend_o),
  .insvc_o  (insvc_o),
  .int_o    (int_o),
  .ev_drop  (ev_drop),
  .ev_take  (ev_take),
  .ev_leave (ev_leave),
  .ev_block (ev_block)
);

// File: tb/test_irq_src_fsm.sv
`timescale 1ns/1ps
module test_irq_src_fsm;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ack = 1'b0, reti = 1'b0;
  logic pend, insvc, intr;
  int   n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  irq_src_fsm i_irq_src_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .reti_i(reti),
    .pend_o(pend), .insvc_o(insvc), .int_o(intr)
  );

  // Bench model: state as {pending, in_service}; 0 idle, 1 service, 2 pending
  function automatic int model(int st, bit r, bit a, bit t);
    if (!r) return 0;
    if (st == 1) return t ? 0 : 1;
    if (st == 2 && a) return 1;
    return 2;
  endfunction

  function automatic string tag(int st, bit r, bit a, bit t);
    if (!r) return "R1";
    if (st == 1 && t) return "R4";
    if (st == 1) return "R2";
    if (st == 2 && a) return "R6";
    if (a || t) return "R7";
    return "R3";
  endfunction

  task automatic check(string req_tag, int exp_st);
    bit ep = (exp_st == 2);
    bit es = (exp_st == 1);
    n_chk++;
    if (pend !== ep || insvc !== es || intr !== ep) begin
      n_fail++;
      $display("FAIL %s: pend/insvc/int = %b%b%b expected %b%b%b",
               req_tag, pend, insvc, intr, ep, es, ep);
    end
  endtask

  task automatic step(bit r, bit a, bit t);
    @(negedge clk);
    req = r; ack = a; reti = t;
    @(posedge clk);
    #1;
  endtask

  task automatic go_to(int st);
    step(0, 0, 0);
    if (st >= 1) step(1, 0, 0);
    if (st == 1) step(1, 1, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", 0);               // reset held low
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0);
    check("R8", 0);

    // Exhaustive: each state x each input combination
    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 8; v++) begin
        bit r = v[2];
        bit a = v[1];
        bit t = v[0];
        go_to(st);
        step(r, a, t);
        check(tag(st, r, a, t), model(st, r, a, t));
        check("R9", model(st, r, a, t));
      end
    end

    // R5: request held through return; idle cycle before pending again
    go_to(1);
    step(1, 0, 1);
    check("R5", 0);
    step(1, 0, 0);
    check("R5", 2);
    // R2: repeated acknowledge during service cannot re-take it
    step(1, 1, 0);
    check("R6", 1);
    step(1, 1, 0);
    check("R2", 1);
    step(1, 1, 0);
    check("R2", 1);

    // R8: reset in service
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", 0);
    @(negedge clk);
    rst_n = 1'b1;
    req = 0; ack = 0; reti = 0;
    step(0, 0, 0);
    check("R8", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule